// File: doc/BRIEF.md
# Bus Controller Intermessage Gap Timer

This block decides when a serial avionics bus controller may begin its next message. When the end-of-message transfer sequence of the current message completes, the block is loaded with a gap value in microseconds. It waits out that gap on a microsecond timebase made by dividing the system clock. When the wait is over, it raises a one-cycle go pulse.

The controller's internal transfer sequences run at the start and at the end of each message. The host may be allowed to take the memory between two of these internal transfers. Each such granted access costs the controller a fixed number of clock cycles. This block models that cost. It grants at most one host access per internal transfer while the enhanced-host-access bit is set. It adds a fixed penalty for every grant, up to a ceiling, and inserts the accumulated penalty, plus a fixed overhead in enhanced controller mode, ahead of the microsecond gap. The transfer sequences, the memory arbiter and the message encoding are outside this block. They appear here only as strobes and busy levels.

Top module: `bc_gap_timer`

## Requirements
- R1: After reset, `go` and `host_grant` are 0, and `go` stays 0 for as long as no `eom_strobe` arrives.
- R2: The microsecond divisor is taken from `clk_sel` as 0 -> 10, 1 -> 12, 2 -> 16, 3 -> 20 clock cycles, so the gap phase lasts `gap_us` times that divisor.
- R3: If `eom_strobe` is sampled high at clock edge E0, `go` is high for exactly one cycle, after edge E0 + S + G*D + 1. Here S is the stretch in cycles, G is `gap_us` and D is the divisor.
- R4: With G = 0 and S = 0, `go` rises after the first edge that follows E0.
- R5: With `enh_host` = 1, every host access granted while `som_busy` or `eom_busy` is high adds 6 cycles to S.
- R6: At most one access is granted per transfer slot. A slot ends with an `xfer_strobe` pulse, and that strobe's own cycle belongs to the ending slot. Further requests in the same slot are ignored. Each grant shows as a one-cycle `host_grant` pulse one cycle after it is granted.
- R7: The accumulated access penalty saturates at 72 cycles.
- R8: With `enh_host` = 0, no access is granted during the sequences and the gap is not stretched.
- R9: With `enh_mode` = 1 at E0, S includes an extra 10 cycles.
- R10: A new `eom_strobe` restarts the timing from its own edge. It also clears the penalty accumulated so far, so that penalty counts only toward the gap that strobe starts.
- R11: `gap_us`, `clk_sel` and `enh_mode` are sampled only at E0. Changes to them afterwards have no effect on the gap in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Clock-rate select, picks the microsecond divisor |
| gap_us | input | 16 | Programmed gap in microseconds |
| enh_host | input | 1 | Allows host accesses between internal transfers |
| enh_mode | input | 1 | Enhanced controller mode, adds fixed overhead |
| som_busy | input | 1 | Start-of-message transfer sequence in progress |
| eom_busy | input | 1 | End-of-message transfer sequence in progress |
| xfer_strobe | input | 1 | Pulse closing one internal transfer slot |
| host_req | input | 1 | Host memory access request |
| eom_strobe | input | 1 | Pulse: end-of-message sequence complete, start gap |
| host_grant | output | 1 | Registered pulse per granted host access |
| go | output | 1 | One-cycle pulse: next message may start |

## Verification
The assertions watch the properties that hold every cycle. These are: `go` never lasts longer than one cycle, and it follows only an active gap. A strobe always starts a gap. The penalty never exceeds its ceiling. No second grant falls inside one slot. No grant is issued while `enh_host` is clear. The microsecond counter stays inside its divisor. The exact latency from strobe to `go` can be seen only in the bench's scenarios. That latency combines the grant count, the per-grant cost, the ceiling, the enhanced-mode overhead, the selected divisor, a restart and the sampling of the settings at the strobe.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_RUN = 1'b1} gap_st_t;
endpackage

// File: rtl/bcg_us_tick.sv
module bcg_us_tick #(
  parameter int DIV0 = 10,
  parameter int DIV1 = 12,
  parameter int DIV2 = 16,
  parameter int DIV3 = 20,
  localparam int DMAX = (DIV0 > DIV1 ? (DIV0 > DIV2 ? (DIV0 > DIV3 ? DIV0 : DIV3) : (DIV2 > DIV3 ? DIV2 : DIV3))
                                     : (DIV1 > DIV2 ? (DIV1 > DIV3 ? DIV1 : DIV3) : (DIV2 > DIV3 ? DIV2 : DIV3))),
  localparam int DW = $clog2(DMAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] sel,
  input  logic       en,
  output logic       tick
);
  logic [DW-1:0] lim_q, cnt_q;

  function automatic logic [DW-1:0] pick(input logic [1:0] s);
    case (s)
      2'd0:    pick = DW'(DIV0);
      2'd1:    pick = DW'(DIV1);
      2'd2:    pick = DW'(DIV2);
      default: pick = DW'(DIV3);
    endcase
  endfunction

  assign tick = en && (cnt_q == lim_q - DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= DW'(DIV0);
      cnt_q <= '0;
    end else if (load) begin
      lim_q <= pick(sel);
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= tick ? '0 : cnt_q + DW'(1);
    end
  end

  // R2: the divider count stays below the latched divisor
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst) cnt_q < lim_q)
    else $error("divider count out of range");
endmodule

// File: rtl/bcg_stretch_acct.sv
module bcg_stretch_acct #(
  parameter int PEN_STEP = 6,
  parameter int PEN_MAX  = 72,
  localparam int PW = $clog2(PEN_MAX + PEN_STEP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enh_host,
  input  logic          som_busy,
  input  logic          eom_busy,
  input  logic          xfer_strobe,
  input  logic          host_req,
  input  logic          clear,
  output logic          host_grant,
  output logic [PW-1:0] pen
);
  logic slot_used_q, grant;
  logic [PW-1:0] pen_sum;

  assign grant   = host_req && (som_busy || eom_busy) && enh_host && !slot_used_q;
  assign pen_sum = pen + PW'(PEN_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_used_q <= 1'b0;
      host_grant  <= 1'b0;
      pen         <= '0;
    end else begin
      slot_used_q <= xfer_strobe ? 1'b0 : (slot_used_q | grant);
      host_grant  <= grant;
      if (clear)
        pen <= '0;
      else if (grant)
        pen <= (pen_sum > PW'(PEN_MAX)) ? PW'(PEN_MAX) : pen_sum;
    end
  end

  // R7: penalty ceiling
  a_r7_pen_cap: assert property (@(posedge clk) disable iff (rst) pen <= PW'(PEN_MAX))
    else $error("penalty above ceiling");
  // R6: no second grant inside one slot
  a_r6_one_per_slot: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(grant) && !$past(xfer_strobe)) |-> !grant)
    else $error("second grant in a slot");
  // R8: no grant with enhanced host access disabled
  a_r8_no_grant_off: assert property (@(posedge clk) disable iff (rst) !enh_host |-> !grant)
    else $error("grant while host access disabled");
endmodule

// File: rtl/bcg_gap_ctrl.sv
module bcg_gap_ctrl
  import bcg_pkg::*;
#(
  parameter int GAP_W     = 16,
  parameter int PW        = 7,
  parameter int PEN_MAX   = 72,
  parameter int ENH_EXTRA = 10,
  localparam int SW = $clog2(PEN_MAX + ENH_EXTRA + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PW-1:0]    pen,
  input  logic             enh_mode,
  input  logic [GAP_W-1:0] gap_us,
  input  logic             tick,
  output logic             tick_en,
  output logic             go
);
  gap_st_t          st_q;
  logic [SW-1:0]    stretch_q;
  logic [GAP_W-1:0] us_q;

  assign tick_en = (st_q == ST_RUN) && (stretch_q == '0) && (us_q != '0) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      stretch_q <= '0;
      us_q      <= '0;
      go        <= 1'b0;
    end else begin
      go <= 1'b0;
      if (load) begin
        st_q      <= ST_RUN;
        stretch_q <= SW'(pen) + (enh_mode ? SW'(ENH_EXTRA) : SW'(0));
        us_q      <= gap_us;
      end else if (st_q == ST_RUN) begin
        if (stretch_q != '0)
          stretch_q <= stretch_q - SW'(1);
        else if (us_q != '0) begin
          if (tick) us_q <= us_q - GAP_W'(1);
        end else begin
          go   <= 1'b1;
          st_q <= ST_IDLE;
        end
      end
    end
  end

  // R3: go lasts one cycle
  a_r3_go_single: assert property (@(posedge clk) disable iff (rst) go |=> !go)
    else $error("go longer than one cycle");
  // R3: go only closes an active gap
  a_r3_go_after_run: assert property (@(posedge clk) disable iff (rst)
    go |-> ($past(st_q) == ST_RUN))
    else $error("go without active gap");
  // R10: every strobe starts a gap and suppresses go
  a_r10_load_starts: assert property (@(posedge clk) disable iff (rst)
    load |=> (st_q == ST_RUN) && !go)
    else $error("strobe did not start a gap");
endmodule

// File: rtl/bc_gap_timer.sv
module bc_gap_timer #(
  parameter int GAP_W     = 16,
  parameter int DIV0      = 10,
  parameter int DIV1      = 12,
  parameter int DIV2      = 16,
  parameter int DIV3      = 20,
  parameter int PEN_STEP  = 6,
  parameter int PEN_MAX   = 72,
  parameter int ENH_EXTRA = 10,
  localparam int PW = $clog2(PEN_MAX + PEN_STEP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       clk_sel,
  input  logic [GAP_W-1:0] gap_us,
  input  logic             enh_host,
  input  logic             enh_mode,
  input  logic             som_busy,
  input  logic             eom_busy,
  input  logic             xfer_strobe,
  input  logic             host_req,
  input  logic             eom_strobe,
  output logic             host_grant,
  output logic             go
);
  logic [PW-1:0] pen;
  logic          tick, tick_en;

  bcg_stretch_acct #(.PEN_STEP(PEN_STEP), .PEN_MAX(PEN_MAX)) u_acct (
    .clk(clk), .rst(rst), .enh_host(enh_host), .som_busy(som_busy),
    .eom_busy(eom_busy), .xfer_strobe(xfer_strobe), .host_req(host_req),
    .clear(eom_strobe), .host_grant(host_grant), .pen(pen));

  bcg_us_tick #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_tick (
    .clk(clk), .rst(rst), .load(eom_strobe), .sel(clk_sel), .en(tick_en), .tick(tick));

  bcg_gap_ctrl #(.GAP_W(GAP_W), .PW(PW), .PEN_MAX(PEN_MAX), .ENH_EXTRA(ENH_EXTRA)) u_ctrl (
    .clk(clk), .rst(rst), .load(eom_strobe), .pen(pen), .enh_mode(enh_mode),
    .gap_us(gap_us), .tick(tick), .tick_en(tick_en), .go(go));
endmodule

// File: tb/bc_gap_timer_bench.sv
module bc_gap_timer_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] clk_sel = '0;
  logic [15:0] gap_us = '0;
  logic enh_host = 1'b0, enh_mode = 1'b0, som_busy = 1'b0, eom_busy = 1'b0;
  logic xfer_strobe = 1'b0, host_req = 1'b0, eom_strobe = 1'b0;
  logic host_grant, go;
  int checks = 0, errors = 0, cyc = 0, gcount = 0, grants_exp = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bc_gap_timer u_bc_gap_timer (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected < 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (host_grant) gcount++;

  function automatic int divof(input logic [1:0] s);
    case (s) 2'd0: return 10; 2'd1: return 12; 2'd2: return 16; default: return 20; endcase
  endfunction

  function automatic int stretch_exp(input int grants, input bit em);
    int p = grants * 6;
    if (p > 72) p = 72;
    return p + (em ? 10 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one sequence of n transfer slots, 3 cycles each; mode 0 random requests, 1 all requests
  task automatic run_seq(input int n, input bit eom, input int mode);
    for (int i = 0; i < n; i++) begin
      bit any = 0;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        som_busy = !eom; eom_busy = eom;
        host_req = (mode == 1) ? 1'b1 : 1'($urandom % 2);
        xfer_strobe = (c == 2);
        if (host_req) any = 1;
      end
      if (any && enh_host) grants_exp++;
    end
    @(negedge clk);
    som_busy = 0; eom_busy = 0; host_req = 0; xfer_strobe = 0;
  endtask

  // strobe and measure latency; settings scrambled after E0 (R11)
  task automatic strobe_measure(input int exp_lat, input string req);
    int k = 0;
    bit seen = 0;
    @(negedge clk); eom_strobe = 1;
    @(negedge clk); eom_strobe = 0;
    gap_us = 16'($urandom); clk_sel = 2'($urandom); enh_mode = 1'($urandom);
    while (!seen && k < exp_lat + 5) begin
      @(negedge clk); k++;
      if (go) seen = 1;
    end
    chk(seen && k == exp_lat, req, seen ? k : -1, exp_lat);
    @(negedge clk);
    chk(go == 1'b0, "R3 go single cycle", int'(go), 0);
  endtask

  task automatic message(input int som_n, input int eom_n, input int mode,
                         input int g, input logic [1:0] sel, input bit em, input string req);
    int s;
    grants_exp = 0;
    gcount = 0;
    run_seq(som_n, 1'b0, mode);
    repeat (4) @(negedge clk);
    run_seq(eom_n, 1'b1, mode);
    repeat (2) @(negedge clk);
    chk(gcount == grants_exp, "R6/R8 grant count", gcount, grants_exp);
    gap_us = 16'(g); clk_sel = sel; enh_mode = em;
    s = stretch_exp(grants_exp, em);
    strobe_measure(s + g * divof(sel) + 1, req);
  endtask

  initial begin
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(go == 0 && host_grant == 0, "R1 reset outputs", int'(go), 0);
    begin
      bit any_go = 0;
      repeat (20) begin @(negedge clk); if (go) any_go = 1; end
      chk(!any_go, "R1 no go without strobe", int'(any_go), 0);
    end
    // R4 zero gap, no stretch
    enh_host = 0;
    message(0, 0, 0, 0, 2'd0, 1'b0, "R4 zero gap latency");
    // R2 each divisor
    for (int s = 0; s < 4; s++) begin
      enh_host = 0;
      message(0, 0, 0, 3, 2'(s), 1'b0, "R2 divisor latency");
    end
    // R9 enhanced overhead
    enh_host = 0;
    message(0, 0, 0, 2, 2'd1, 1'b1, "R9 enhanced overhead");
    // R5 all slots granted: 12 grants -> 72
    enh_host = 1;
    message(7, 5, 1, 1, 2'd3, 1'b0, "R5 full stretch");
    // R7 saturation: 19 grants, capped at 72
    enh_host = 1;
    message(14, 5, 1, 0, 2'd0, 1'b1, "R7 penalty cap");
    // R8 host access disabled, all requests
    enh_host = 0;
    message(7, 5, 1, 2, 2'd2, 1'b0, "R8 no stretch when disabled");
    // long gap
    enh_host = 0;
    message(0, 0, 0, 1000, 2'd0, 1'b0, "R2 long gap");
    // R10 restart: accumulate, strobe, strobe again mid-gap
    begin
      int k = 0;
      bit early = 0, seen = 0;
      enh_host = 1; grants_exp = 0;
      run_seq(5, 1'b1, 1);
      gap_us = 50; clk_sel = 0; enh_mode = 0;
      @(negedge clk); eom_strobe = 1;
      @(negedge clk); eom_strobe = 0;
      repeat (40) begin @(negedge clk); if (go) early = 1; end
      gap_us = 2; clk_sel = 2'd1; enh_mode = 1;
      @(negedge clk); eom_strobe = 1;
      @(negedge clk); eom_strobe = 0;
      while (!seen && k < 60) begin
        @(negedge clk); k++;
        if (go) seen = 1;
      end
      chk(!early && seen && k == 10 + 2 * 12 + 1, "R10 restart clears penalty",
          seen ? k : -1, 35);
    end
    // random mix (R3/R5/R6/R11)
    for (int it = 0; it < 25; it++) begin
      enh_host = 1'($urandom);
      message(7, 5, 0, int'($urandom % 21), 2'($urandom), 1'($urandom), "R3 random latency");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule